// File: doc/BRIEF.md
# HyperBus Read/Write Master Controller

This block is the host side of a HyperBus memory link. A request on the user side starts one burst transaction. The request carries a byte address, a direction, a word count and a zero-latency flag. The controller lowers chip select while the bus clock rests low. It then shifts out a 48-bit command/address, one byte on every CK edge, most significant byte first. After that comes the programmed number of latency clocks, followed by the burst of 16-bit data words.

CK is produced as a toggle of a register on every cycle of the system clock. One CK edge therefore corresponds to one byte slot. Write data leaves the controller aligned with CK, and RWDS is held low so that no byte is masked. Read bytes are taken whenever the device-driven RWDS strobe changes level. On a read, the controller keeps CK running until the last requested word has arrived, so it does not depend on the device's latency. Every transaction ends the same way: CK is parked low, and then chip select is released.

Top module: `hb_master`

## Requirements
- R1: After reset, cs_n=1, ck=0, ck_n=1, dq_oe=0, rwds_oe=0 and req_ready=1.
- R2: A request is taken in a cycle where req_valid and req_ready are both 1. In the following cycle cs_n is 0 while ck is still 0, and the first CK edge comes one cycle later.
- R3: The command/address goes out as six bytes, one per CK edge, starting with bits 47:40. Bit 47 is 1 for a read and 0 for a write, bit 46 is 0, and bit 45 is 1.
- R4: Command/address bits 44:16 carry req_addr divided by 16, bits 3:0 carry req_addr modulo 16, and bits 15:4 are zero.
- R5: For a write with req_zero_lat=0, the six address bytes are followed by exactly 2*cfg_latency CK edges with dq_oe=0, and then the data bytes.
- R6: For a write with req_zero_lat=1, or with cfg_latency=0, the first data byte is on the CK edge right after the sixth address byte.
- R7: A write sends req_len+1 words, each with bits 15:8 first. wr_ready is high for one cycle per word, and wr_data is taken in that cycle. rwds_oe=1 with rwds_out=0 throughout the data bytes.
- R8: During a read, each level change of rwds_in captures dq_in. The first byte of a pair is bits 15:8. rd_valid pulses for one cycle with the word in rd_data.
- R9: A read delivers exactly req_len+1 words and then ends, whatever latency the device inserts.
- R10: ck is 0 whenever cs_n is 1, and ck_n is always the complement of ck. At the end of a transaction ck is 0 for at least one cycle before cs_n rises.
- R11: req_ready stays 0 from the cycle after acceptance until cs_n is back at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one CK edge per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Transaction request |
| req_ready | output | 1 | Controller idle, request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_zero_lat | input | 1 | Write without initial latency |
| req_addr | input | ADDR_W | Target byte address |
| req_len | input | LEN_W | Word count minus one |
| cfg_latency | input | LAT_W | Latency in CK periods |
| wr_data | input | 16 | Write word, taken while wr_ready |
| wr_ready | output | 1 | Write word is consumed this cycle |
| rd_data | output | 16 | Received read word |
| rd_valid | output | 1 | rd_data valid pulse |
| cs_n | output | 1 | Chip select, active low |
| ck | output | 1 | Bus clock |
| ck_n | output | 1 | Complement of ck |
| dq_out | output | 8 | Data bus drive value |
| dq_oe | output | 1 | Data bus drive enable |
| dq_in | input | 8 | Data bus received value |
| rwds_out | output | 1 | Strobe/mask drive value |
| rwds_oe | output | 1 | Strobe/mask drive enable |
| rwds_in | input | 1 | Strobe from the device |

## Verification
Writes are run three ways: with a nonzero latency, with the zero-latency flag, and with a latency setting of zero. Counting the idle CK edges in these runs separates a latency counter that is off by one from a zero-latency branch that is wrongly taken. Reads are answered by a device model that starts its strobe after an even edge count in one run and an odd count in another. This shows that capture follows RWDS rather than CK, and that the read ends on the word count and not on a fixed number of clocks. The addresses have nonzero low nibbles and high bits set, which exposes a misplaced row or column field. A maximum-length write at the maximum latency covers the counter limits.

// File: rtl/hb_pkg.sv
// Package: shared state encoding and widths for the HyperBus master.
package hb_pkg;
    localparam int CA_W = 48;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CSLO, ST_CA, ST_LAT, ST_WDAT, ST_RDAT, ST_STOP, ST_FIN
    } hb_state_e;
endpackage

// File: rtl/hb_ca_build.sv
// Module: hb_ca_build
// Forms the 48-bit command/address word from the request.
// Assumes ADDR_W is between 5 and 33 so that addr/16 fits the 29-bit field.
module hb_ca_build #(
    parameter int ADDR_W = 32
) (
    input  logic              is_write,
    input  logic [ADDR_W-1:0] addr,
    output logic [47:0]       ca
);
    localparam int UPPER_W = 29;
    logic [UPPER_W-1:0] upper_fld;

    // Field split: word-row part and low nibble.
    always_comb begin
        upper_fld = UPPER_W'(addr >> 4);
        ca = {~is_write, 1'b0, 1'b1, upper_fld, 12'h000, addr[3:0]};
    end
endmodule

// File: rtl/hb_rd_capture.sv
// Module: hb_rd_capture
// Takes a dq_in byte on every RWDS level change while active and pairs the
// bytes into 16-bit words (first byte high). Assumes rwds_in and dq_in are
// stable around the sampling edge of clk.
module hb_rd_capture (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        active,
    input  logic        rwds_in,
    input  logic [7:0]  dq_in,
    output logic        rd_valid,
    output logic [15:0] rd_data
);
    logic       rwds_q;
    logic       half;
    logic [7:0] hi_byte;

    // Edge detect on the strobe and byte pairing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rwds_q   <= 1'b0;
            half     <= 1'b0;
            hi_byte  <= 8'h00;
            rd_valid <= 1'b0;
            rd_data  <= 16'h0000;
        end else begin
            rwds_q   <= rwds_in;
            rd_valid <= 1'b0;
            if (!active) begin
                half <= 1'b0;
            end else if (rwds_in != rwds_q) begin
                if (!half) begin
                    hi_byte <= dq_in;
                    half    <= 1'b1;
                end else begin
                    rd_data  <= {hi_byte, dq_in};
                    rd_valid <= 1'b1;
                    half     <= 1'b0;
                end
            end
        end
    end

    // R8: a word appears only from a capture window
    assert_rd_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(active));
endmodule

// File: rtl/hb_seq.sv
// Module: hb_seq
// Transaction sequencer: chip select, CK toggling, address shift-out,
// latency counting, write data launch and read word counting.
// Assumes the capture block reports one pulse per received word.
module hb_seq
    import hb_pkg::*;
#(
    parameter int LEN_W = 4,
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic             req_zero_lat,
    input  logic [LEN_W-1:0] req_len,
    input  logic [LAT_W-1:0] cfg_latency,
    input  logic [47:0]      ca_word,
    input  logic [15:0]      wr_data,
    output logic             wr_ready,
    input  logic             rd_word_valid,
    output logic             rd_active,
    output logic             cs_n,
    output logic             ck,
    output logic [7:0]       dq_out,
    output logic             dq_oe,
    output logic             rwds_out,
    output logic             rwds_oe
);
    localparam int CNT_W = ((LAT_W > LEN_W) ? LAT_W : LEN_W) + 2;

    hb_state_e        state;
    logic [47:0]      ca_sr;
    logic [CNT_W-1:0] cnt;
    logic [LEN_W-1:0] len_q;
    logic [LAT_W-1:0] lat_q;
    logic             wr_q, zl_q, ph;
    logic [7:0]       lo_byte;
    logic [CNT_W-1:0] lat_last;
    logic [CNT_W-1:0] len_ext;

    // Handshake and phase decodes.
    always_comb begin
        req_ready = (state == ST_IDLE);
        wr_ready  = (state == ST_WDAT) && !ph;
        rd_active = (state == ST_RDAT);
        rwds_out  = 1'b0;
        lat_last  = {CNT_W'(lat_q), 1'b0} - CNT_W'(1);
        len_ext   = CNT_W'(len_q);
    end

    // Main sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cs_n    <= 1'b1;
            ck      <= 1'b0;
            dq_out  <= 8'h00;
            dq_oe   <= 1'b0;
            rwds_oe <= 1'b0;
            ca_sr   <= '0;
            cnt     <= '0;
            len_q   <= '0;
            lat_q   <= '0;
            wr_q    <= 1'b0;
            zl_q    <= 1'b0;
            ph      <= 1'b0;
            lo_byte <= 8'h00;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    cs_n  <= 1'b0;
                    ca_sr <= ca_word;
                    wr_q  <= req_write;
                    zl_q  <= req_zero_lat;
                    len_q <= req_len;
                    lat_q <= cfg_latency;
                    state <= ST_CSLO;
                end
                ST_CSLO: begin
                    ck     <= ~ck;
                    dq_out <= ca_sr[47:40];
                    ca_sr  <= {ca_sr[39:0], 8'h00};
                    dq_oe  <= 1'b1;
                    cnt    <= CNT_W'(1);
                    state  <= ST_CA;
                end
                ST_CA: begin
                    ck     <= ~ck;
                    dq_out <= ca_sr[47:40];
                    ca_sr  <= {ca_sr[39:0], 8'h00};
                    cnt    <= cnt + CNT_W'(1);
                    if (cnt == CNT_W'(5)) begin
                        cnt <= '0;
                        ph  <= 1'b0;
                        if (!wr_q)                       state <= ST_RDAT;
                        else if (zl_q || lat_q == '0)    state <= ST_WDAT;
                        else                             state <= ST_LAT;
                    end
                end
                ST_LAT: begin
                    ck    <= ~ck;
                    dq_oe <= 1'b0;
                    cnt   <= cnt + CNT_W'(1);
                    if (cnt == lat_last) begin
                        cnt   <= '0;
                        state <= ST_WDAT;
                    end
                end
                ST_WDAT: begin
                    ck      <= ~ck;
                    dq_oe   <= 1'b1;
                    rwds_oe <= 1'b1;
                    ph      <= ~ph;
                    if (!ph) begin
                        dq_out  <= wr_data[15:8];
                        lo_byte <= wr_data[7:0];
                    end else begin
                        dq_out <= lo_byte;
                        cnt    <= cnt + CNT_W'(1);
                        if (cnt == len_ext) state <= ST_STOP;
                    end
                end
                ST_RDAT: begin
                    ck    <= ~ck;
                    dq_oe <= 1'b0;
                    if (rd_word_valid) begin
                        cnt <= cnt + CNT_W'(1);
                        if (cnt == len_ext) state <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    ck      <= 1'b0;
                    dq_oe   <= 1'b0;
                    rwds_oe <= 1'b0;
                    state   <= ST_FIN;
                end
                default: begin
                    cs_n  <= 1'b1;
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // R10: clock rests low while deselected
    assert_ck_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !ck);
    // R2: chip select falls with the clock idle
    assert_cs_fall_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> !ck);
    // R10: clock parked low before chip select rises
    assert_cs_rise_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (!ck && !$past(ck)));
    // R7: RWDS driven only low and only alongside write data
    assert_rwds_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rwds_oe |-> (!rwds_out && dq_oe));
    // R11: no acceptance while a transaction holds the bus
    assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> !req_ready);
endmodule

// File: rtl/hb_master.sv
// Module: hb_master (top)
// HyperBus host controller: joins the address builder, the sequencer and the
// read capture. One CK edge per clk cycle; the PHY alignment is external.
module hb_master #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 4,
    parameter int LAT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_zero_lat,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [LAT_W-1:0]  cfg_latency,
    input  logic [15:0]       wr_data,
    output logic              wr_ready,
    output logic [15:0]       rd_data,
    output logic              rd_valid,
    output logic              cs_n,
    output logic              ck,
    output logic              ck_n,
    output logic [7:0]        dq_out,
    output logic              dq_oe,
    input  logic [7:0]        dq_in,
    output logic              rwds_out,
    output logic              rwds_oe,
    input  logic              rwds_in
);
    logic [47:0] ca_word;
    logic        rd_active;

    // Complementary clock output.
    assign ck_n = ~ck;

    hb_ca_build #(.ADDR_W(ADDR_W)) ca_i (
        .is_write (req_write),
        .addr     (req_addr),
        .ca       (ca_word)
    );

    hb_seq #(.LEN_W(LEN_W), .LAT_W(LAT_W)) seq_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_write     (req_write),
        .req_zero_lat  (req_zero_lat),
        .req_len       (req_len),
        .cfg_latency   (cfg_latency),
        .ca_word       (ca_word),
        .wr_data       (wr_data),
        .wr_ready      (wr_ready),
        .rd_word_valid (rd_valid),
        .rd_active     (rd_active),
        .cs_n          (cs_n),
        .ck            (ck),
        .dq_out        (dq_out),
        .dq_oe         (dq_oe),
        .rwds_out      (rwds_out),
        .rwds_oe       (rwds_oe)
    );

    hb_rd_capture cap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (rd_active),
        .rwds_in  (rwds_in),
        .dq_in    (dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );
endmodule

// File: tb/hb_master_tb_top.sv
// Bench: scoreboard of expected bus bytes and read words, with a device model.
module hb_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_zero_lat = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_len = '0, cfg_latency = '0;
    logic [15:0] wr_data = '0;
    logic        req_ready, wr_ready, rd_valid, cs_n, ck, ck_n, dq_oe;
    logic        rwds_out, rwds_oe;
    logic [15:0] rd_data;
    logic [7:0]  dq_out;
    logic [7:0]  dq_in = '0;
    logic        rwds_in = 1'b0;

    always #2.5 clk = ~clk;

    hb_master dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_zero_lat(req_zero_lat), .req_addr(req_addr),
        .req_len(req_len), .cfg_latency(cfg_latency), .wr_data(wr_data),
        .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
        .cs_n(cs_n), .ck(ck), .ck_n(ck_n), .dq_out(dq_out), .dq_oe(dq_oe),
        .dq_in(dq_in), .rwds_out(rwds_out), .rwds_oe(rwds_oe), .rwds_in(rwds_in)
    );

    int n_cmp = 0, n_bad = 0;
    logic [7:0]  exp_bytes[$];
    logic [15:0] wq[$];
    logic [15:0] exp_rd[$];
    logic [7:0]  dev_bytes[$];
    int  exp_lat = 0, lat_edges = 0, dev_edges = 0, dev_lat = 0, byte_idx = 0;
    bit  is_wr = 1'b0, txn_done = 1'b0, mon_on = 1'b0;
    logic ckp = 1'b0, csp = 1'b1;

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor and device model, away from the active edge.
    always @(negedge clk) begin
        if (mon_on) begin
            if (wr_ready) wr_data = (wq.size() > 0) ? wq.pop_front() : 16'hDEAD;
            if (ck_n != ~ck) chk(0, "R10 ck_n", ck_n, ~ck);
            if (cs_n && ck) chk(0, "R10 ck idle", ck, 0);
            if (!cs_n && req_ready) chk(0, "R11 busy ready", req_ready, 0);
            if (!cs_n && csp) chk(!ck, "R2 cs fall ck low", ck, 0);
            if (!cs_n && ck != ckp) begin
                if (dq_oe) begin
                    if (exp_bytes.size() == 0) chk(0, "R3 extra byte", dq_out, 0);
                    else begin
                        logic [7:0] e;
                        e = exp_bytes.pop_front();
                        chk(dq_out == e, byte_idx < 6 ? "R3/R4 ca byte" : "R7 data byte",
                            dq_out, e);
                        if (byte_idx >= 6) chk(rwds_oe && !rwds_out, "R7 rwds low", rwds_out, 0);
                    end
                    byte_idx++;
                end else begin
                    lat_edges++;
                    if (!is_wr) begin
                        dev_edges++;
                        if (dev_edges > dev_lat && dev_bytes.size() > 0) begin
                            dq_in   = dev_bytes.pop_front();
                            rwds_in = ~rwds_in;
                        end
                    end
                end
            end
            if (rd_valid) begin
                if (exp_rd.size() == 0) chk(0, "R9 extra word", rd_data, 0);
                else begin
                    logic [15:0] w;
                    w = exp_rd.pop_front();
                    chk(rd_data == w, "R8 read word", rd_data, w);
                end
            end
            if (cs_n && !csp) begin
                chk(!ck && !ckp, "R10 ck low before cs rise", ckp, 0);
                chk(exp_bytes.size() == 0, "R3 bytes missing", exp_bytes.size(), 0);
                if (is_wr) chk(lat_edges == exp_lat, "R5/R6 latency edges", lat_edges, exp_lat);
                else chk(exp_rd.size() == 0, "R9 words missing", exp_rd.size(), 0);
                txn_done = 1'b1;
            end
            ckp = ck;
            csp = cs_n;
        end
    end

    // Driver: push expectations, issue one request, wait for its end.
    task automatic run_txn(bit wr, bit zl, logic [31:0] addr, int words, int lat, int dlat);
        logic [47:0] ca;
        ca = {~wr, 1'b0, 1'b1, 29'(addr >> 4), 12'h000, addr[3:0]};
        for (int i = 0; i < 6; i++) exp_bytes.push_back(ca[47-8*i -: 8]);
        for (int i = 0; i < words; i++) begin
            logic [15:0] w;
            w = 16'hA50F ^ 16'(i * 16'h1357) ^ addr[15:0];
            if (wr) begin
                wq.push_back(w);
                exp_bytes.push_back(w[15:8]);
                exp_bytes.push_back(w[7:0]);
            end else begin
                dev_bytes.push_back(w[15:8]);
                dev_bytes.push_back(w[7:0]);
                exp_rd.push_back(w);
            end
        end
        is_wr = wr; exp_lat = (zl || !wr) ? 0 : 2 * lat; dev_lat = dlat;
        lat_edges = 0; dev_edges = 0; byte_idx = 0; txn_done = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_zero_lat = zl; req_addr = addr;
        req_len = 4'(words - 1); cfg_latency = 4'(lat);
        chk(req_ready, "R2 ready at request", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!cs_n && !ck, "R2 cs low clock idle", {cs_n, ck}, 0);
        while (!txn_done) @(negedge clk);
        @(negedge clk);
        chk(req_ready && cs_n, "R11 ready after end", req_ready, 1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk({cs_n, ck, ck_n, dq_oe, rwds_oe, req_ready} == 6'b101001, "R1 reset outputs",
            {cs_n, ck, ck_n, dq_oe, rwds_oe, req_ready}, 6'b101001);
        mon_on = 1'b1;
        run_txn(1, 0, 32'h1234_5678, 4, 3, 0);   // R5 latency write
        run_txn(1, 1, 32'h0000_0ABC, 2, 5, 0);   // R6 zero-latency flag
        run_txn(1, 0, 32'hFFFF_FFF1, 1, 0, 0);   // R6 latency setting zero
        run_txn(0, 0, 32'hABCD_EF0F, 3, 6, 8);   // R8 read, even device latency
        run_txn(0, 0, 32'h8000_0007, 16, 6, 13); // R9 read, odd latency, max length
        run_txn(1, 0, 32'h0F0F_0F0E, 16, 15, 0); // R5/R7 limits
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hang counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog R9 actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule